// File: doc/BRIEF.md
# DMA Channel Termination Controller

This block keeps the operand bookkeeping for one DMA channel and decides when the channel stops. A start command loads a 16-bit operand counter, a memory-side address and a device-side address, and raises the active flag. A bus sequencer then reports each operand and each of its bus cycles. On every completed operand the block counts down and advances whichever addresses are enabled. The channel ends in one of two ways. In the normal way the count runs out. In the other, the peripheral signals end-of-data on its DONE line.

When requests come from the peripheral, the block drives its own DONE output during the final bus cycle of the last operand. It also watches the peripheral's DONE. That input is only believed once it has been held over two clock edges. The window in which it is honoured depends on the addressing mode. A word operand to a byte-wide port that is cut short by the peripheral still closes as one operand, but it moves the addresses by only one byte. A one-cycle pulse marks every termination.

Top module: `dma_term_ctl`

## Requirements
- R1: A start command while the channel is idle loads count, memory address and device address from the init inputs. One cycle later `act_o`=1, `coc_o`=0 and `ndt_o`=0. A start command while `act_o`=1 changes nothing.
- R2: `done_o` is 1 exactly when `ext_req_i`=1, an operand is in flight, the current bus cycle is that operand's last one, and the count equals 1.
- R3: When an operand completes with count 1, the next cycle shows count 0, `act_o`=0, `coc_o`=1 and `ndt_o`=0, unless R9 applies.
- R4: Each completed operand lowers the count by 1. Each address whose step enable is 1 rises by 2 for a word operand and by 1 for a byte operand.
- R5: The peripheral's DONE counts as seen in a cycle only if it was sampled high at each of the two rising edges before that cycle. A level present at a single edge is ignored.
- R6: In single-address mode (`dual_addr_i`=0), a seen DONE is recognised only in a cycle where `dev_cyc_i`=1 and `dtc_i`=1.
- R7: In dual-address mode, a seen DONE is recognised in any cycle while an operand is in flight, whatever `dev_cyc_i` and `dtc_i` are.
- R8: An operand is a word (`op_word_i`=1) to a byte port (`port8_i`=1), so it takes two bus cycles. If DONE is recognised before or during its first cycle, the operand closes when that cycle completes. The count falls by 1 and each enabled address rises by 1.
- R9: Once DONE is recognised, the channel terminates when the operand's closing cycle completes. The next cycle shows `act_o`=0, `coc_o`=1 and `ndt_o`=1, with the count and addresses updated as in R4 and R8.
- R10: A peripheral DONE that arrives while `done_o` is 1 is not recognised. The channel ends as in R3, with `ndt_o`=0.
- R11: `term_o` is high for exactly one cycle per termination, and only in the cycle after it. `act_o` stays 0 until the next start command, and operand or bus-cycle strobes while idle change nothing.
- R12: With `ext_req_i`=0, `done_o` stays 0 and the peripheral's DONE is never recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start command (load and activate) |
| cnt_init_i | input | 16 | Operand count loaded on start |
| mar_init_i | input | 24 | Memory address loaded on start |
| dar_init_i | input | 24 | Device address loaded on start |
| ext_req_i | input | 1 | 1 = requests come from the peripheral |
| dual_addr_i | input | 1 | 1 = dual-address transfers, 0 = single-address |
| mar_step_en_i | input | 1 | Advance the memory address per operand |
| dar_step_en_i | input | 1 | Advance the device address per operand |
| op_start_i | input | 1 | An operand transfer begins |
| op_word_i | input | 1 | Operand is a word (sampled with op_start_i) |
| port8_i | input | 1 | Port is 8 bits wide (sampled with op_start_i) |
| cyc_done_i | input | 1 | Current bus cycle completes |
| dev_cyc_i | input | 1 | Current bus cycle addresses the device |
| dtc_i | input | 1 | Device transfer complete strobe |
| done_in_i | input | 1 | DONE level driven by the peripheral |
| done_o | output | 1 | DONE driven by the channel |
| act_o | output | 1 | Channel active |
| coc_o | output | 1 | Channel operation complete |
| ndt_o | output | 1 | Ended by the peripheral |
| term_o | output | 1 | One-cycle termination pulse |
| count_o | output | 16 | Remaining operand count |
| mar_o | output | 24 | Memory address |
| dar_o | output | 24 | Device address |

## Verification
Every registered result appears one cycle after the edge that samples its cause. This covers the count, the addresses, `act_o`, `coc_o`, `ndt_o` and `term_o`. `done_o` is combinational from that state, so it is due in the same cycle the state shows the last beat. A peripheral DONE must sit across two edges before it can act, so a termination it causes appears at the earliest on the third edge after the level rises. The bench drives inputs just after the falling edge and updates its reference model at the rising edge. It compares every output at the following falling edge, so each comparison lands in the cycle the result is due.

// File: rtl/dmat_pkg.sv
package dmat_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_XFER = 2'd2
  } ch_state_e;

  // Address advance per closed operand: full word unless the word was cut.
  function automatic logic [1:0] step_bytes(input logic word, input logic cut);
    return (word && !cut) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/dmat_rst_sync.sv
module dmat_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/dmat_done_filt.sv
module dmat_done_filt #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_in_i,
  output logic seen_o
);

  logic [STAGES-1:0] hist_q, hist_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb hist_d = done_in_i;
    end else begin : g_many
      always_comb hist_d = {hist_q[STAGES-2:0], done_in_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign seen_o = &hist_q;

endmodule

// File: rtl/dmat_seq.sv
module dmat_seq
  import dmat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ext_req_i,
  input  logic dual_addr_i,
  input  logic op_start_i,
  input  logic op_word_i,
  input  logic port8_i,
  input  logic cyc_done_i,
  input  logic dev_cyc_i,
  input  logic dtc_i,
  input  logic seen_i,
  input  logic cnt_one_i,
  output logic load_o,
  output logic close_o,
  output logic step2_o,
  output logic done_o,
  output logic act_o,
  output logic coc_o,
  output logic ndt_o,
  output logic term_o
);

  ch_state_e state_q, state_d;
  logic two_beat_q, two_beat_d;
  logic beat_q, beat_d;
  logic word_q, word_d;
  logic pend_q, pend_d;
  logic coc_q, coc_d;
  logic ndt_q, ndt_d;
  logic term_q, term_d;

  logic xfer, last_beat, own_done, window, recog, cut_req;
  logic close, short_op, finish;

  always_comb begin
    xfer      = (state_q == CH_XFER);
    last_beat = !two_beat_q || beat_q;
    own_done  = ext_req_i && xfer && last_beat && cnt_one_i;
    window    = dual_addr_i || (dev_cyc_i && dtc_i);
    recog     = ext_req_i && xfer && seen_i && window && !own_done;
    cut_req   = pend_q || recog;
    close     = xfer && cyc_done_i && (last_beat || cut_req);
    short_op  = close && !last_beat;
    finish    = close && (cnt_one_i || cut_req);
  end

  always_comb begin
    state_d    = state_q;
    two_beat_d = two_beat_q;
    beat_d     = beat_q;
    word_d     = word_q;
    pend_d     = pend_q;
    coc_d      = coc_q;
    ndt_d      = ndt_q;
    term_d     = 1'b0;
    unique case (state_q)
      CH_IDLE: begin
        if (start_i) begin
          state_d = CH_WAIT;
          coc_d   = 1'b0;
          ndt_d   = 1'b0;
        end
      end
      CH_WAIT: begin
        if (op_start_i) begin
          state_d    = CH_XFER;
          two_beat_d = op_word_i && port8_i;
          beat_d     = 1'b0;
          word_d     = op_word_i;
          pend_d     = 1'b0;
        end
      end
      CH_XFER: begin
        if (close) begin
          if (finish) begin
            state_d = CH_IDLE;
            coc_d   = 1'b1;
            ndt_d   = cut_req;
            term_d  = 1'b1;
          end else begin
            state_d = CH_WAIT;
          end
        end else begin
          if (cyc_done_i) beat_d = 1'b1;
          if (recog)      pend_d = 1'b1;
        end
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CH_IDLE;
      two_beat_q <= 1'b0;
      beat_q     <= 1'b0;
      word_q     <= 1'b0;
      pend_q     <= 1'b0;
      coc_q      <= 1'b0;
      ndt_q      <= 1'b0;
      term_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      two_beat_q <= two_beat_d;
      beat_q     <= beat_d;
      word_q     <= word_d;
      pend_q     <= pend_d;
      coc_q      <= coc_d;
      ndt_q      <= ndt_d;
      term_q     <= term_d;
    end
  end

  assign load_o  = (state_q == CH_IDLE) && start_i;
  assign close_o = close;
  assign step2_o = step_bytes(word_q, short_op) == 2'd2;
  assign done_o  = own_done;
  assign act_o   = (state_q != CH_IDLE);
  assign coc_o   = coc_q;
  assign ndt_o   = ndt_q;
  assign term_o  = term_q;

endmodule

// File: rtl/dmat_dp.sv
module dmat_dp #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              close_i,
  input  logic              step2_i,
  input  logic              mar_en_i,
  input  logic              dar_en_i,
  input  logic [CNT_W-1:0]  cnt_init_i,
  input  logic [ADDR_W-1:0] mar_init_i,
  input  logic [ADDR_W-1:0] dar_init_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [ADDR_W-1:0] dar_o,
  output logic              cnt_one_o
);

  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
  localparam logic [ADDR_W-1:0] STEP_B  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_W  = ADDR_W'(2);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] mar_q, mar_d, dar_q, dar_d, step;
  logic              cnt_en, mar_upd, dar_upd;

  always_comb begin
    step    = step2_i ? STEP_W : STEP_B;
    cnt_en  = load_i || close_i;
    mar_upd = load_i || (close_i && mar_en_i);
    dar_upd = load_i || (close_i && dar_en_i);
    cnt_d   = load_i ? cnt_init_i : (cnt_q - CNT_ONE);
    mar_d   = load_i ? mar_init_i : (mar_q + step);
    dar_d   = load_i ? dar_init_i : (dar_q + step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mar_q <= '0;
    else if (mar_upd) mar_q <= mar_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dar_q <= '0;
    else if (dar_upd) dar_q <= dar_d;
  end

  assign count_o   = cnt_q;
  assign mar_o     = mar_q;
  assign dar_o     = dar_q;
  assign cnt_one_o = (cnt_q == CNT_ONE);

endmodule

// File: rtl/dma_term_ctl.sv
module dma_term_ctl #(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 24,
  parameter int DONE_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cnt_init_i,
  input  logic [ADDR_W-1:0] mar_init_i,
  input  logic [ADDR_W-1:0] dar_init_i,
  input  logic              ext_req_i,
  input  logic              dual_addr_i,
  input  logic              mar_step_en_i,
  input  logic              dar_step_en_i,
  input  logic              op_start_i,
  input  logic              op_word_i,
  input  logic              port8_i,
  input  logic              cyc_done_i,
  input  logic              dev_cyc_i,
  input  logic              dtc_i,
  input  logic              done_in_i,
  output logic              done_o,
  output logic              act_o,
  output logic              coc_o,
  output logic              ndt_o,
  output logic              term_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [ADDR_W-1:0] dar_o
);

  logic rst_sync_n;
  logic seen, load, close, step2, cnt_one;

  dmat_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_sync_n)
  );

  dmat_done_filt #(.STAGES(DONE_STAGES)) u_filt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .done_in_i(done_in_i),
    .seen_o   (seen)
  );

  dmat_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .ext_req_i  (ext_req_i),
    .dual_addr_i(dual_addr_i),
    .op_start_i (op_start_i),
    .op_word_i  (op_word_i),
    .port8_i    (port8_i),
    .cyc_done_i (cyc_done_i),
    .dev_cyc_i  (dev_cyc_i),
    .dtc_i      (dtc_i),
    .seen_i     (seen),
    .cnt_one_i  (cnt_one),
    .load_o     (load),
    .close_o    (close),
    .step2_o    (step2),
    .done_o     (done_o),
    .act_o      (act_o),
    .coc_o      (coc_o),
    .ndt_o      (ndt_o),
    .term_o     (term_o)
  );

  dmat_dp #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (load),
    .close_i   (close),
    .step2_i   (step2),
    .mar_en_i  (mar_step_en_i),
    .dar_en_i  (dar_step_en_i),
    .cnt_init_i(cnt_init_i),
    .mar_init_i(mar_init_i),
    .dar_init_i(dar_init_i),
    .count_o   (count_o),
    .mar_o     (mar_o),
    .dar_o     (dar_o),
    .cnt_one_o (cnt_one)
  );

endmodule

// File: rtl/dma_term_chk.sv
module dma_term_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             ext_req_i,
  input logic             done_o,
  input logic             act_o,
  input logic             coc_o,
  input logic             ndt_o,
  input logic             term_o,
  input logic [CNT_W-1:0] count_o
);

  a_r1_start_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_o && start_i) |=> (act_o && !coc_o && !ndt_o));

  a_r2_done_at_last_count: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (act_o && count_o == CNT_W'(1)));

  a_r3_term_sets_complete: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> (coc_o && !act_o));

  a_r4_count_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o && $past(act_o) && count_o != $past(count_o)) |->
      ((count_o + CNT_W'(1)) == $past(count_o)));

  a_r9_ndt_implies_coc: assert property (@(posedge clk) disable iff (!rst_n)
    ndt_o |-> coc_o);

  a_r11_term_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |=> !term_o);

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_o && !start_i) |=> !act_o);

  a_r12_no_done_internal: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_req_i |-> !done_o);

endmodule

bind dma_term_ctl dma_term_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start_i  (start_i),
  .ext_req_i(ext_req_i),
  .done_o   (done_o),
  .act_o    (act_o),
  .coc_o    (coc_o),
  .ndt_o    (ndt_o),
  .term_o   (term_o),
  .count_o  (count_o)
);

// File: tb/sim_dma_term_ctl.sv
`timescale 1ns/1ps
module sim_dma_term_ctl;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        start_i, ext_req_i, dual_addr_i, mar_step_en_i, dar_step_en_i;
  logic        op_start_i, op_word_i, port8_i, cyc_done_i, dev_cyc_i, dtc_i, done_in_i;
  logic [15:0] cnt_init_i;
  logic [23:0] mar_init_i, dar_init_i;
  logic        done_o, act_o, coc_o, ndt_o, term_o;
  logic [15:0] count_o;
  logic [23:0] mar_o, dar_o;

  dma_term_ctl u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cnt_init_i(cnt_init_i),
    .mar_init_i(mar_init_i), .dar_init_i(dar_init_i), .ext_req_i(ext_req_i),
    .dual_addr_i(dual_addr_i), .mar_step_en_i(mar_step_en_i),
    .dar_step_en_i(dar_step_en_i), .op_start_i(op_start_i), .op_word_i(op_word_i),
    .port8_i(port8_i), .cyc_done_i(cyc_done_i), .dev_cyc_i(dev_cyc_i),
    .dtc_i(dtc_i), .done_in_i(done_in_i), .done_o(done_o), .act_o(act_o),
    .coc_o(coc_o), .ndt_o(ndt_o), .term_o(term_o), .count_o(count_o),
    .mar_o(mar_o), .dar_o(dar_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_en = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_st, m_two, m_beat, m_word, m_pend, m_coc, m_ndt, m_term;
  int          m_run, m_r1, m_r2;
  logic [15:0] m_cnt;
  logic [23:0] m_mar, m_dar;

  task automatic m_clear();
    m_st = 0; m_two = 0; m_beat = 0; m_word = 0; m_pend = 0;
    m_coc = 0; m_ndt = 0; m_term = 0; m_run = 0;
    m_cnt = '0; m_mar = '0; m_dar = '0;
  endtask

  function automatic bit m_done();
    bit last_b;
    last_b = (m_two == 0) || (m_beat != 0);
    return ext_req_i && (m_st == 2) && last_b && (m_cnt == 16'd1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(); m_r1 = 0; m_r2 = 0;
    end else begin
      int old_r;
      old_r = m_r2; m_r2 = m_r1; m_r1 = 1;
      if (old_r == 0) m_clear();
      else begin
        bit last_b, own, rec, cut, cls;
        int stp;
        last_b = (m_two == 0) || (m_beat != 0);
        own    = m_done();
        rec    = ext_req_i && (m_st == 2) && (m_run >= 2) &&
                 (dual_addr_i || (dev_cyc_i && dtc_i)) && !own;
        cut    = (m_pend != 0) || rec;
        cls    = (m_st == 2) && cyc_done_i && (last_b || cut);
        m_term = 0;
        if (m_st == 0) begin
          if (start_i) begin
            m_st = 1; m_coc = 0; m_ndt = 0;
            m_cnt = cnt_init_i; m_mar = mar_init_i; m_dar = dar_init_i;
          end
        end else if (m_st == 1) begin
          if (op_start_i) begin
            m_st = 2; m_two = op_word_i && port8_i; m_beat = 0;
            m_word = op_word_i; m_pend = 0;
          end
        end else begin
          if (cls) begin
            stp = (m_word != 0 && last_b) ? 2 : 1;
            if (mar_step_en_i) m_mar = m_mar + 24'(stp);
            if (dar_step_en_i) m_dar = m_dar + 24'(stp);
            if (m_cnt == 16'd1 || cut) begin
              m_st = 0; m_coc = 1; m_ndt = cut; m_term = 1;
            end else m_st = 1;
            m_cnt = m_cnt - 16'd1;
          end else begin
            if (cyc_done_i) m_beat = 1;
            if (rec) m_pend = 1;
          end
        end
        m_run = done_in_i ? ((m_run < 3) ? m_run + 1 : 3) : 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R1 act", act_o, (m_st != 0));
      chk("R2 done", done_o, m_done());
      chk("R3 coc", coc_o, m_coc);
      chk("R9 ndt", ndt_o, m_ndt);
      chk("R11 term", term_o, m_term);
      chk("R4 count", count_o, m_cnt);
      chk("R4 mar", mar_o, m_mar);
      chk("R4 dar", dar_o, m_dar);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic start_ch(input int cnt, input int mar, input int dar);
    start_i = 1; cnt_init_i = 16'(cnt); mar_init_i = 24'(mar); dar_init_i = 24'(dar);
    step(1); start_i = 0;
  endtask

  task automatic op(input bit word, input bit p8);
    op_start_i = 1; op_word_i = word; port8_i = p8; step(1); op_start_i = 0;
  endtask

  task automatic bus(input bit dev, input bit dtc);
    cyc_done_i = 1; dev_cyc_i = dev; dtc_i = dtc; step(1);
    cyc_done_i = 0; dev_cyc_i = 0; dtc_i = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; start_i = 0; ext_req_i = 1; dual_addr_i = 0;
    mar_step_en_i = 1; dar_step_en_i = 0; op_start_i = 0; op_word_i = 0;
    port8_i = 0; cyc_done_i = 0; dev_cyc_i = 0; dtc_i = 0; done_in_i = 0;
    cnt_init_i = 0; mar_init_i = 0; dar_init_i = 0;
    step(3); rst_n = 1; step(4); cmp_en = 1;
    chk("R1 reset act", act_o, 0); chk("R1 reset count", count_o, 0);
    chk("R3 reset coc", coc_o, 0); chk("R11 reset term", term_o, 0);

    // R3 / R4 / R1: byte operands count out normally
    start_ch(3, 'h100, 'h200);
    chk("R1 active after start", act_o, 1);
    op(0, 0); bus(1, 1);
    start_ch(9, 'h999, 'h999);
    chk("R1 start ignored while active", count_o, 2);
    op(0, 0); bus(1, 1);
    op(0, 0);
    chk("R2 done on last operand", done_o, 1);
    bus(1, 1);
    chk("R11 term pulse", term_o, 1); chk("R3 coc", coc_o, 1);
    chk("R3 ndt clear", ndt_o, 0); chk("R4 mar +3", mar_o, 'h103);
    step(1);
    chk("R11 term one cycle", term_o, 0);

    // R4: word operands, both addresses step
    dar_step_en_i = 1;
    start_ch(2, 'h400, 'h800);
    op(1, 0); bus(1, 1); op(1, 0); bus(1, 1);
    chk("R4 mar +4", mar_o, 'h404); chk("R4 dar +4", dar_o, 'h804);
    op(0, 0); bus(1, 1); step(1);
    chk("R11 idle strobes ignored count", count_o, 0);
    chk("R11 idle stays inactive", act_o, 0);
    dar_step_en_i = 0;

    // R6 / R9: single mode needs dev cycle with dtc
    start_ch(5, 'h1000, 0);
    done_in_i = 1; step(2);
    op(0, 0); bus(1, 0);
    chk("R6 no dtc no stop", act_o, 1); chk("R6 count", count_o, 4);
    op(0, 0); bus(1, 1);
    chk("R9 ndt set", ndt_o, 1); chk("R9 coc set", coc_o, 1);
    chk("R9 count", count_o, 3); chk("R9 mar", mar_o, 'h1002);
    done_in_i = 0; step(2);

    // R5: single-edge DONE is ignored
    start_ch(4, 'h2000, 0);
    op(0, 0);
    done_in_i = 1; bus(1, 1); done_in_i = 0;
    chk("R5 glitch ignored act", act_o, 1); chk("R5 glitch ndt", ndt_o, 0);
    chk("R5 count", count_o, 3);
    op(0, 0); bus(1, 1); op(0, 0); bus(1, 1); op(0, 0); bus(1, 1);
    step(1);

    // R7 / R8: dual mode, word to byte port cut to one byte
    dual_addr_i = 1; dar_step_en_i = 1;
    start_ch(4, 'h3000, 'h5000);
    op(1, 1);
    done_in_i = 1; step(2);
    bus(0, 0);
    chk("R7 recognised off device cycle", ndt_o, 1);
    chk("R8 count", count_o, 3); chk("R8 mar +1", mar_o, 'h3001);
    chk("R8 dar +1", dar_o, 'h5001);
    done_in_i = 0; dual_addr_i = 0; dar_step_en_i = 0; step(2);

    // R10: peripheral DONE while own DONE is driven
    start_ch(1, 'h6000, 0);
    op(1, 0);
    chk("R2 own done", done_o, 1);
    done_in_i = 1; step(2); bus(1, 1);
    chk("R10 ndt clear", ndt_o, 0); chk("R10 coc", coc_o, 1);
    chk("R10 mar", mar_o, 'h6002);
    done_in_i = 0; step(2);

    // R12: internal request mode
    ext_req_i = 0;
    start_ch(2, 'h7000, 0);
    done_in_i = 1; step(2);
    op(0, 0); bus(1, 1);
    chk("R12 no stop", act_o, 1);
    op(0, 0);
    chk("R12 done low", done_o, 0);
    bus(1, 1);
    chk("R12 ndt", ndt_o, 0); chk("R12 coc", coc_o, 1);
    done_in_i = 0; ext_req_i = 1; step(2);

    // random stress against the model
    for (int i = 0; i < 4000; i++) begin
      start_i       = ($urandom_range(0, 7) == 0);
      cnt_init_i    = 16'($urandom_range(1, 6));
      mar_init_i    = 24'($urandom);
      dar_init_i    = 24'($urandom);
      if ($urandom_range(0, 15) == 0) ext_req_i = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) dual_addr_i = $urandom_range(0, 1);
      mar_step_en_i = $urandom_range(0, 1);
      dar_step_en_i = $urandom_range(0, 1);
      op_start_i    = ($urandom_range(0, 3) == 0);
      op_word_i     = $urandom_range(0, 1);
      port8_i       = $urandom_range(0, 1);
      cyc_done_i    = $urandom_range(0, 1);
      dev_cyc_i     = $urandom_range(0, 1);
      dtc_i         = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) done_in_i = ~done_in_i;
      step(1);
    end
    start_i = 0; op_start_i = 0; cyc_done_i = 0; done_in_i = 0;
    step(3);
    summary();
    $finish;
  end

endmodule